// File: doc/BRIEF.md
# Grey Value Reorderer with Dropped-Slot Fill

This block sits after a set of eight parallel lookup banks in an inverse-halftoning datapath. Four templates are fetched per group and each is steered to one bank. When two templates want the same bank, the lower-numbered one loses and never produces a result. Each bank that did produce a result presents an 8-bit grey value together with a 3-bit tag. The tag names the template (1 to 4) that the value belongs to.

For each group the block scans all eight bank ports and gathers the values by tag into four slots. The slots are held in fetch order. A slot with no result takes the grey value of the nearest higher-numbered slot that did receive one. The four grey values are registered and presented one cycle after the group strobe, together with a valid flag.

Top module: `grey_reorder`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, out_valid is 0 and out_grey is all zeros.
- R2: out_valid equals the value of in_valid one clock earlier.
- R3: Slot k (k = 1..4) receives the grey value of the port whose valid bit is 1 and whose tag equals k. Tag values are binary: 001, 010, 011 and 100. Slot k is output on out_grey bits [8k-1 : 8k-8], so slot 1 is in the least significant byte. The port number carrying a tag has no effect on where its value lands.
- R4: A port whose valid bit is 0 has no effect on the outputs, whatever its tag. A port whose tag is 000, 101, 110 or 111 has no effect either.
- R5: A slot with no matching port copies the output value of the nearest higher-numbered slot that has a match. Several missing slots in a row all take that same value.
- R6: If slot 4 has no matching port, it outputs 0. Any missing slots directly below it then also output 0.
- R7: If more than one valid port carries the same tag, the value from the lowest-numbered such port is used.
- R8: While in_valid is 0, out_grey keeps its previous value, whatever the ports carry.

Top module ports: see the table below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Group strobe: the port contents form one group this cycle |
| port_vld | input | 8 | Per-port result-present flag |
| port_tag | input | 24 | Per-port 3-bit template tag; port p uses bits [3p+2:3p] |
| port_grey | input | 64 | Per-port 8-bit grey value; port p uses bits [8p+7:8p] |
| out_valid | output | 1 | High for one cycle per accepted group |
| out_grey | output | 32 | Four grey values in fetch order; slot k is in bits [8k-1:8k-8] |

## Verification
The assertions on slot placement assume that port 0 has the highest priority. They therefore check only values carried by port 0, and they do not depend on which tags appear twice. The fill assertions assume that every group has been registered through in_valid, and they compare each missing slot with its upper neighbour. The stimulus places each present tag on one distinct, randomly chosen port. Free ports are filled with ignorable decoys: ports with the valid bit low, tag 000, or tags 101 to 111. Two tags appear twice only in one dedicated group, and the bench reports that group as a protocol error.

// File: rtl/grey_reorder_pkg.sv
package grey_reorder_pkg;
    localparam int DEF_GREY_W    = 8;
    localparam int DEF_TAG_W     = 3;
    localparam int DEF_NUM_PORTS = 8;
    localparam int DEF_NUM_SLOTS = 4;
endpackage

// File: rtl/slot_gather.sv
module slot_gather #(
    parameter int NUM_PORTS = grey_reorder_pkg::DEF_NUM_PORTS,
    parameter int TAG_W     = grey_reorder_pkg::DEF_TAG_W,
    parameter int GREY_W    = grey_reorder_pkg::DEF_GREY_W,
    parameter int SLOT_TAG  = 1
) (
    input  logic [NUM_PORTS-1:0]        port_vld,
    input  logic [NUM_PORTS*TAG_W-1:0]  port_tag,
    input  logic [NUM_PORTS*GREY_W-1:0] port_grey,
    output logic                        hit,
    output logic [GREY_W-1:0]           grey
);
    localparam logic [TAG_W-1:0] MATCH = TAG_W'(SLOT_TAG);

    // Scan from the top port down so the lowest-numbered match is kept last.
    always_comb begin
        hit  = 1'b0;
        grey = '0;
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (port_vld[p] && port_tag[p*TAG_W +: TAG_W] == MATCH) begin
                hit  = 1'b1;
                grey = port_grey[p*GREY_W +: GREY_W];
            end
        end
    end
endmodule

// File: rtl/neighbour_fill.sv
module neighbour_fill #(
    parameter int NUM_SLOTS = grey_reorder_pkg::DEF_NUM_SLOTS,
    parameter int GREY_W    = grey_reorder_pkg::DEF_GREY_W
) (
    input  logic [NUM_SLOTS-1:0]        hit,
    input  logic [NUM_SLOTS*GREY_W-1:0] raw,
    output logic [NUM_SLOTS*GREY_W-1:0] filled
);
    logic [GREY_W-1:0] carry;

    // Walk from the highest slot downwards, carrying the last present value.
    always_comb begin
        carry  = '0;
        filled = '0;
        for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
            if (hit[k]) carry = raw[k*GREY_W +: GREY_W];
            filled[k*GREY_W +: GREY_W] = carry;
        end
    end
endmodule

// File: rtl/grey_reorder.sv
module grey_reorder #(
    parameter int NUM_PORTS = grey_reorder_pkg::DEF_NUM_PORTS,
    parameter int NUM_SLOTS = grey_reorder_pkg::DEF_NUM_SLOTS,
    parameter int TAG_W     = grey_reorder_pkg::DEF_TAG_W,
    parameter int GREY_W    = grey_reorder_pkg::DEF_GREY_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [NUM_PORTS-1:0]        port_vld,
    input  logic [NUM_PORTS*TAG_W-1:0]  port_tag,
    input  logic [NUM_PORTS*GREY_W-1:0] port_grey,
    output logic                        out_valid,
    output logic [NUM_SLOTS*GREY_W-1:0] out_grey
);
    localparam int BUS_W = NUM_SLOTS * GREY_W;

    typedef struct packed {
        logic                 vld;
        logic [NUM_SLOTS-1:0] pres;
        logic [BUS_W-1:0]     grey;
    } state_t;

    logic [NUM_SLOTS-1:0] hit;
    logic [BUS_W-1:0]     raw;
    logic [BUS_W-1:0]     filled;
    state_t               st_d, st_q;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        slot_gather #(
            .NUM_PORTS(NUM_PORTS),
            .TAG_W    (TAG_W),
            .GREY_W   (GREY_W),
            .SLOT_TAG (s + 1)
        ) u_gather (
            .port_vld (port_vld),
            .port_tag (port_tag),
            .port_grey(port_grey),
            .hit      (hit[s]),
            .grey     (raw[s*GREY_W +: GREY_W])
        );
    end

    neighbour_fill #(
        .NUM_SLOTS(NUM_SLOTS),
        .GREY_W   (GREY_W)
    ) u_fill (
        .hit   (hit),
        .raw   (raw),
        .filled(filled)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.pres = hit;
            st_d.grey = filled;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_grey  = st_q.grey;

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_grey));
    // R6
    top_absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !st_q.pres[NUM_SLOTS-1] |-> out_grey[BUS_W-1 -: GREY_W] == '0);

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_chk
        // R3 R7: port 0 always wins, so its value must land in its slot
        port0_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && port_vld[0] && port_tag[TAG_W-1:0] == TAG_W'(k + 1)
            |=> out_grey[k*GREY_W +: GREY_W] == $past(port_grey[GREY_W-1:0]));
        if (k < NUM_SLOTS - 1) begin : g_fill
            // R5
            fill_from_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid && !st_q.pres[k]
                |-> out_grey[k*GREY_W +: GREY_W] == out_grey[(k+1)*GREY_W +: GREY_W]);
        end
    end
endmodule

// File: tb/test_grey_reorder.sv
module test_grey_reorder;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam int NS = 4;
    localparam int GW = 8;
    localparam int TW = 3;
    localparam int WATCHDOG = 50000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [NP-1:0]    port_vld = '0;
    logic [NP*TW-1:0] port_tag = '0;
    logic [NP*GW-1:0] port_grey = '0;
    logic             out_valid;
    logic [NS*GW-1:0] out_grey;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    grey_reorder i_grey_reorder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .port_vld(port_vld), .port_tag(port_tag), .port_grey(port_grey),
        .out_valid(out_valid), .out_grey(out_grey)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [NS*GW-1:0] exp_g, input logic exp_v);
        n_vec++;
        if (out_grey !== exp_g || out_valid !== exp_v) begin
            n_bad++;
            $display("FAIL %s: grey=%h valid=%b, expected grey=%h valid=%b",
                     req, out_grey, out_valid, exp_g, exp_v);
        end
    endtask

    // Fill every port with a decoy that must be ignored (R4).
    task automatic decoy_all();
        for (int p = 0; p < NP; p++) begin
            int kind = int'($urandom % 3);
            port_grey[p*GW +: GW] = GW'($urandom);
            if (kind == 0) begin
                port_vld[p] = 1'b0;
                port_tag[p*TW +: TW] = TW'(1 + $urandom % 4);
            end else if (kind == 1) begin
                port_vld[p] = 1'b1;
                port_tag[p*TW +: TW] = '0;
            end else begin
                port_vld[p] = 1'b1;
                port_tag[p*TW +: TW] = TW'(5 + $urandom % 3);
            end
        end
    endtask

    task automatic run_case(input logic [NS-1:0] mask);
        logic [GW-1:0]    val [NS];
        logic [NP-1:0]    used = '0;
        logic [NS*GW-1:0] exp_g = '0;
        logic [GW-1:0]    carry = '0;
        decoy_all();
        for (int s = 0; s < NS; s++) begin
            val[s] = GW'($urandom);
            if (mask[s]) begin
                int p = int'($urandom % NP);
                while (used[p]) p = (p + 1) % NP;
                used[p] = 1'b1;
                port_vld[p] = 1'b1;
                port_tag[p*TW +: TW] = TW'(s + 1);
                port_grey[p*GW +: GW] = val[s];
            end
        end
        for (int s = NS - 1; s >= 0; s--) begin
            if (mask[s]) carry = val[s];
            exp_g[s*GW +: GW] = carry;
        end
        in_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        if (!mask[NS-1])         check("R6 absent top slot", exp_g, 1'b1);
        else if (mask != '1)     check("R5 neighbour fill", exp_g, 1'b1);
        else                     check("R3 R4 tag placement", exp_g, 1'b1);
        in_valid = 1'b0;
        for (int p = 0; p < NP; p++) begin
            port_vld[p] = 1'b1;
            port_tag[p*TW +: TW] = TW'(1 + $urandom % 4);
            port_grey[p*GW +: GW] = GW'($urandom);
        end
        @(posedge clk); @(negedge clk);
        check("R8 R2 hold while idle", exp_g, 1'b0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        decoy_all();
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 in reset", '0, 1'b0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 after release", '0, 1'b0);

        for (int trial = 0; trial < 24; trial++)
            for (int m = 0; m < (1 << NS); m++)
                run_case(NS'(m));

        // R7: duplicate tags, lowest port wins (protocol error case)
        decoy_all();
        port_vld[6] = 1'b1; port_tag[6*TW +: TW] = 3'd2; port_grey[6*GW +: GW] = 8'hA6;
        port_vld[2] = 1'b1; port_tag[2*TW +: TW] = 3'd2; port_grey[2*GW +: GW] = 8'h22;
        port_vld[7] = 1'b1; port_tag[7*TW +: TW] = 3'd4; port_grey[7*GW +: GW] = 8'h77;
        port_vld[3] = 1'b1; port_tag[3*TW +: TW] = 3'd4; port_grey[3*GW +: GW] = 8'h33;
        port_vld[5] = 1'b1; port_tag[5*TW +: TW] = 3'd1; port_grey[5*GW +: GW] = 8'h15;
        $display("note: protocol error injected, tags 2 and 4 each on two ports");
        in_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R7 lowest port wins", {8'h33, 8'h33, 8'h22, 8'h15}, 1'b1);
        in_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R2 valid drops", {8'h33, 8'h33, 8'h22, 8'h15}, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule